// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table and Pending Controller

This block holds the per-function interrupt vector state of a PCIe endpoint that signals interrupts with message writes. It stores a memory-mapped table with one entry per vector. Each entry carries a 64-bit message address, a 32-bit message data word and a vector-control word whose bit 0 masks the vector. Beside the table it keeps a read-only array of pending bits, one per vector. It also holds the two writable bits of the capability's message-control field: the enable bit and the function-wide mask bit.

Device logic raises interrupt requests by vector number. If the vector can be delivered and the output is free, the block presents the entry's address and data on a valid/ready message port. Otherwise it records a pending bit. Pending bits are delivered, lowest vector first, as soon as their vector is unmasked and the output is free. Clearing either mask level therefore replays any interrupt that arrived while the vector was blocked. Table and pending-array reads are combinational on the register address. The enclosing endpoint does the BAR and capability decoding and provides the select lines.

Top module: `msx_ctrl`

## Requirements
- R1: After reset the enable and mask-all bits are 0, every table word reads 0 except the vector-control word, which reads 1 (vector masked), the pending array reads 0 and `msg_valid` is low.
- R2: The function mask is active when enable (`cfg_ctl_wdata[1]`, field bit 15) is 0 or mask-all (`cfg_ctl_wdata[0]`, field bit 14) is 1. While it is active no message leaves the block and every request on a used vector sets its pending bit. `cfg_ctl_rdata` returns {enable, mask-all}.
- R3: Each table entry is 16 bytes: lower address at byte 0, upper address at 4, data at 8 and vector control at 12. Bit 0 of vector control masks only that vector.
- R4: A request for a used, unmasked vector while the output is free shows the message on the next cycle: `msg_addr` = {upper, lower}, `msg_data` = data word and `msg_vec` = the vector. No pending bit is set.
- R5: When a vector with its pending bit set goes from masked to unmasked, through a table write or a control write, its pending bit clears and its message is sent.
- R6: A message stays on the output, unchanged, until `msg_ready` accepts it. Requests that arrive while it waits become pending bits. These are sent after acceptance in ascending vector order.
- R7: Requests with a vector number of `NUM_VEC` or more, or for a vector whose `vec_used` bit is 0, are dropped with no message and no pending bit. Clearing a `vec_used` bit clears that vector's pending bit.
- R8: `cfg_tbl_size` reports `NUM_VEC`-1. The pending array spans a whole multiple of 64 vectors, and dwords past the last vector read 0.
- R9: Pending bit N is bit N mod 32 of pending-array dword N/32, which is byte N/8, bit N mod 8, in little-endian order. Writes to the pending array have no effect.
- R10: Table words are read and written as whole 32-bit dwords. Writes whose address has nonzero low two bits, or whose entry lies past the table, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register write strobe (reads are combinational) |
| reg_wr | input | 1 | 1 = write access |
| reg_sel_pba | input | 1 | 1 = pending array, 0 = vector table |
| reg_addr | input | RAW | Byte address within the selected region |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| cfg_wr | input | 1 | Write strobe for the control bits |
| cfg_ctl_wdata | input | 2 | {enable, mask-all} |
| cfg_ctl_rdata | output | 2 | Current {enable, mask-all} |
| cfg_tbl_size | output | 11 | Vector count minus one |
| vec_used | input | NUM_VEC | Per-vector in-use flags |
| irq_valid | input | 1 | Interrupt request strobe |
| irq_vec | input | VEC_W | Requested vector number |
| msg_valid | output | 1 | Message write available |
| msg_ready | input | 1 | Message accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| msg_vec | output | VEC_W | Vector the message belongs to |

## Verification
The hardest state to reach from the ports is a backlog of several pending vectors, each unmasked, waiting behind a stalled output. Only that state shows the ascending drain order and the stability of the held message. The bench reaches it by holding `msg_ready` low and unmasking three entries. It then fires one request that occupies the output and two more, out of order, that can only go to the pending array. The array is read back before `msg_ready` is released and the three handshakes are logged. Replay on unmask is provoked both ways: through a table write to one vector's control word and through control writes that lift the function mask.

// File: rtl/msx_pkg.sv
package msx_pkg;

    // One vector-table entry, 4 dwords; word index w occupies bits [w*32 +: 32]
    typedef struct packed {
        logic [31:0] vctrl;    // word 3, bit 0 = per-vector mask
        logic [31:0] data;     // word 2
        logic [31:0] addr_hi;  // word 1
        logic [31:0] addr_lo;  // word 0
    } msx_entry_t;

    localparam msx_entry_t ENTRY_RST = '{vctrl: 32'd1, data: 32'd0, addr_hi: 32'd0, addr_lo: 32'd0};

endpackage

// File: rtl/msx_pick_low.sv
module msx_pick_low #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        any   = |req;
        grant = any ? (N'(1) << idx) : '0;
    end
endmodule

// File: rtl/msx_vec_table.sv
module msx_vec_table
    import msx_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int DW_AW   = 5,
    parameter int IW      = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DW_AW-1:0]   wr_dw,
    input  logic [31:0]        wr_data,
    input  logic [DW_AW-1:0]   rd_dw,
    output logic [31:0]        rd_data,
    input  logic [IW-1:0]      sel_idx,
    output logic [63:0]        sel_addr,
    output logic [31:0]        sel_data,
    output logic [NUM_VEC-1:0] mask
);
    localparam int VIW = DW_AW - 2;

    msx_entry_t [NUM_VEC-1:0] tbl_d, tbl_q;

    logic [VIW-1:0] wr_vi, rd_vi;
    logic [1:0]     wr_ws, rd_ws;

    assign wr_vi = wr_dw[DW_AW-1:2];
    assign wr_ws = wr_dw[1:0];
    assign rd_vi = rd_dw[DW_AW-1:2];
    assign rd_ws = rd_dw[1:0];

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en && int'(wr_vi) < NUM_VEC) begin
            tbl_d[wr_vi][int'(wr_ws)*32 +: 32] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= {NUM_VEC{ENTRY_RST}};
        else        tbl_q <= tbl_d;
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_vi) < NUM_VEC) rd_data = tbl_q[rd_vi][int'(rd_ws)*32 +: 32];
        sel_addr = {tbl_q[sel_idx].addr_hi, tbl_q[sel_idx].addr_lo};
        sel_data = tbl_q[sel_idx].data;
        for (int i = 0; i < NUM_VEC; i++) mask[i] = tbl_q[i].vctrl[0];
    end

    // R10: table contents move only on a write
    a_r10_table_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(tbl_q));

endmodule

// File: rtl/msx_ctrl.sv
module msx_ctrl
    import msx_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int VEC_W   = 12,
    parameter int RAW     = ($clog2(NUM_VEC * 16) < 5) ? 5 : $clog2(NUM_VEC * 16)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_req,
    input  logic               reg_wr,
    input  logic               reg_sel_pba,
    input  logic [RAW-1:0]     reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               cfg_wr,
    input  logic [1:0]         cfg_ctl_wdata,
    output logic [1:0]         cfg_ctl_rdata,
    output logic [10:0]        cfg_tbl_size,
    input  logic [NUM_VEC-1:0] vec_used,
    input  logic               irq_valid,
    input  logic [VEC_W-1:0]   irq_vec,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data,
    output logic [VEC_W-1:0]   msg_vec
);
    localparam int IW       = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
    localparam int DW_AW    = RAW - 2;
    localparam int PBA_BITS = 64 * ((NUM_VEC + 63) / 64);
    localparam int PBA_DW   = PBA_BITS / 32;

    typedef struct packed {
        logic               en;
        logic               mall;
        logic [NUM_VEC-1:0] pend;
        logic               mvalid;
        logic [63:0]        maddr;
        logic [31:0]        mdata;
        logic [VEC_W-1:0]   mvec;
    } ctl_t;

    ctl_t st_d, st_q;

    logic               aligned, tbl_wr;
    logic [31:0]        tbl_rdata, pba_word;
    logic [NUM_VEC-1:0] vmask, mask_eff, req_hot, elig, grant;
    logic [IW-1:0]      gidx;
    logic               gany, fn_mask, out_free;
    logic [63:0]        sel_addr;
    logic [31:0]        sel_data;
    logic [PBA_BITS-1:0] pba_pad;
    logic [DW_AW-1:0]   dw;

    assign aligned = (reg_addr[1:0] == 2'b00);
    assign dw      = reg_addr[RAW-1:2];
    assign tbl_wr  = reg_req && reg_wr && !reg_sel_pba && aligned;

    msx_vec_table #(.NUM_VEC(NUM_VEC), .DW_AW(DW_AW), .IW(IW)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr),
        .wr_dw    (dw),
        .wr_data  (reg_wdata),
        .rd_dw    (dw),
        .rd_data  (tbl_rdata),
        .sel_idx  (gidx),
        .sel_addr (sel_addr),
        .sel_data (sel_data),
        .mask     (vmask)
    );

    msx_pick_low #(.N(NUM_VEC), .IW(IW)) u_pick (
        .req   (elig),
        .grant (grant),
        .idx   (gidx),
        .any   (gany)
    );

    always_comb begin
        fn_mask  = !st_q.en || st_q.mall;
        mask_eff = vmask | {NUM_VEC{fn_mask}};
        for (int i = 0; i < NUM_VEC; i++) begin
            req_hot[i] = irq_valid && (int'(irq_vec) == i) && vec_used[i];
        end
        elig     = (st_q.pend & ~mask_eff & vec_used) | (req_hot & ~mask_eff);
        out_free = !st_q.mvalid || msg_ready;
    end

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.en   = cfg_ctl_wdata[1];
            st_d.mall = cfg_ctl_wdata[0];
        end
        st_d.pend = (st_q.pend | req_hot) & ~((out_free && gany) ? grant : '0) & vec_used;
        if (out_free) begin
            st_d.mvalid = gany;
            if (gany) begin
                st_d.maddr = sel_addr;
                st_d.mdata = sel_data;
                st_d.mvec  = VEC_W'(gidx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        pba_pad  = PBA_BITS'(st_q.pend);
        pba_word = '0;
        for (int k = 0; k < PBA_DW; k++) begin
            if (int'(dw) == k) pba_word = pba_pad[k*32 +: 32];
        end
        reg_rdata = !aligned ? '0 : (reg_sel_pba ? pba_word : tbl_rdata);
    end

    assign cfg_ctl_rdata = {st_q.en, st_q.mall};
    assign cfg_tbl_size  = 11'(NUM_VEC - 1);
    assign msg_valid     = st_q.mvalid;
    assign msg_addr      = st_q.maddr;
    assign msg_data      = st_q.mdata;
    assign msg_vec       = st_q.mvec;

    // R6: a waiting message is held unchanged
    a_r6_hold_until_accept: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data) && $stable(msg_vec));

    // R7: an unused vector never keeps a pending bit
    a_r7_unused_no_pending: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.pend & ~$past(vec_used)) == '0);

    // R7: a pending bit only appears for an accepted request on that vector
    a_r7_pending_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.pend & ~$past(st_q.pend)) & ~$past(req_hot)) == '0);

    // R2: a fresh message only leaves when the function mask was clear
    a_r2_send_needs_fn_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> $past(st_q.en && !st_q.mall));

    // R7: messages only name vectors inside the table
    a_r7_msg_vec_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> int'(msg_vec) < NUM_VEC);

endmodule

// File: tb/tb_msx_ctrl.sv
module tb_msx_ctrl;
    localparam int NUM_VEC = 8;
    localparam int VEC_W   = 12;
    localparam int RAW     = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_req = 0, reg_wr = 0, reg_sel_pba = 0;
    logic [RAW-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic cfg_wr = 0;
    logic [1:0] cfg_ctl_wdata = '0, cfg_ctl_rdata;
    logic [10:0] cfg_tbl_size;
    logic [NUM_VEC-1:0] vec_used = '1;
    logic irq_valid = 0;
    logic [VEC_W-1:0] irq_vec = '0;
    logic msg_valid, msg_ready = 1'b1;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;
    logic [VEC_W-1:0] msg_vec;

    int n_chk = 0, n_fail = 0, nlog = 0;
    logic [VEC_W-1:0] log_vec [0:31];
    logic [63:0] log_addr [0:31];
    logic [31:0] log_data [0:31];

    always #10 clk = ~clk;

    msx_ctrl #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .RAW(RAW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_wr(reg_wr), .reg_sel_pba(reg_sel_pba),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_wr(cfg_wr),
        .cfg_ctl_wdata(cfg_ctl_wdata), .cfg_ctl_rdata(cfg_ctl_rdata), .cfg_tbl_size(cfg_tbl_size),
        .vec_used(vec_used), .irq_valid(irq_valid), .irq_vec(irq_vec), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data), .msg_vec(msg_vec));

    always @(posedge clk) begin
        if (rst_n && msg_valid && msg_ready && nlog < 32) begin
            log_vec[nlog]  <= msg_vec;
            log_addr[nlog] <= msg_addr;
            log_data[nlog] <= msg_data;
            nlog <= nlog + 1;
        end
    end

    function automatic logic [63:0] exp_addr(int v);
        return {32'h0000_0010 + 32'(v), 32'hFEE0_0000 | 32'(v << 4)};
    endfunction
    function automatic logic [31:0] exp_data(int v);
        return 32'h0000_4100 + 32'(v);
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic twr(int v, int w, logic [31:0] d);
        @(negedge clk);
        reg_req = 1; reg_wr = 1; reg_sel_pba = 0; reg_addr = RAW'(v * 16 + w * 4); reg_wdata = d;
        @(negedge clk);
        reg_req = 0; reg_wr = 0;
    endtask

    task automatic pwr(int dword, logic [31:0] d);
        @(negedge clk);
        reg_req = 1; reg_wr = 1; reg_sel_pba = 1; reg_addr = RAW'(dword * 4); reg_wdata = d;
        @(negedge clk);
        reg_req = 0; reg_wr = 0; reg_sel_pba = 0;
    endtask

    task automatic trd(int v, int w, output logic [31:0] d);
        reg_sel_pba = 0; reg_addr = RAW'(v * 16 + w * 4);
        #1 d = reg_rdata;
    endtask

    task automatic prd(int dword, output logic [31:0] d);
        reg_sel_pba = 1; reg_addr = RAW'(dword * 4);
        #1 d = reg_rdata;
        reg_sel_pba = 0;
    endtask

    task automatic cfg(logic en, logic mall);
        @(negedge clk);
        cfg_wr = 1; cfg_ctl_wdata = {en, mall};
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic irq(int v);
        @(negedge clk);
        irq_valid = 1; irq_vec = VEC_W'(v);
        @(negedge clk);
        irq_valid = 0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        @(negedge clk);
        check("R1 ctrl bits", 64'(cfg_ctl_rdata), 64'd0);
        trd(3, 3, d); check("R1 vctrl masked", 64'(d), 64'd1);
        trd(3, 0, d); check("R1 addr zero", 64'(d), 64'd0);
        prd(0, d);    check("R1 pba zero", 64'(d), 64'd0);
        check("R1 no msg", 64'(msg_valid), 64'd0);
        check("R8 table size", 64'(cfg_tbl_size), 64'd7);
    endtask

    task automatic t_program();
        logic [31:0] d;
        for (int v = 0; v < NUM_VEC; v++) begin
            twr(v, 0, exp_addr(v)[31:0]);
            twr(v, 1, exp_addr(v)[63:32]);
            twr(v, 2, exp_data(v));
        end
        trd(5, 1, d); check("R3 upper addr word", 64'(d), 64'(exp_addr(5)[63:32]));
        trd(5, 2, d); check("R3 data word", 64'(d), 64'(exp_data(5)));
    endtask

    task automatic t_disabled_then_enable();
        logic [31:0] d;
        int base;
        twr(2, 3, 32'd0);
        base = nlog;
        irq(2);
        cyc(2);
        check("R2 no msg while disabled", 64'(nlog - base), 64'd0);
        prd(0, d); check("R2 pending set while disabled", 64'(d), 64'h4);
        cfg(1'b1, 1'b0);
        check("R2 ctrl readback", 64'(cfg_ctl_rdata), 64'h2);
        cyc(3);
        check("R5 replay on enable count", 64'(nlog - base), 64'd1);
        check("R4 message vector", 64'(log_vec[base]), 64'd2);
        check("R4 message address", log_addr[base], exp_addr(2));
        check("R4 message data", 64'(log_data[base]), 64'(exp_data(2)));
        prd(0, d); check("R5 pending cleared", 64'(d), 64'h0);
    endtask

    task automatic t_vector_mask();
        logic [31:0] d;
        int base;
        base = nlog;
        irq(6);
        cyc(2);
        check("R3 masked vector no msg", 64'(nlog - base), 64'd0);
        prd(0, d); check("R9 pending bit 6", 64'(d), 64'h40);
        twr(6, 3, 32'd0);
        cyc(3);
        check("R5 replay on table unmask", 64'(nlog - base), 64'd1);
        check("R5 replay vector", 64'(log_vec[base]), 64'd6);
        prd(0, d); check("R5 pending cleared", 64'(d), 64'h0);
        base = nlog;
        irq(6);
        prd(0, d); check("R4 direct no pending", 64'(d), 64'h0);
        cyc(2);
        check("R4 direct message", 64'(nlog - base), 64'd1);
    endtask

    task automatic t_mask_all();
        logic [31:0] d;
        int base;
        cfg(1'b1, 1'b1);
        base = nlog;
        irq(6);
        irq(2);
        cyc(2);
        check("R2 mask-all blocks", 64'(nlog - base), 64'd0);
        prd(0, d); check("R2 pending under mask-all", 64'(d), 64'h44);
        cfg(1'b1, 1'b0);
        cyc(4);
        check("R5 replay count", 64'(nlog - base), 64'd2);
        check("R6 ascending first", 64'(log_vec[base]), 64'd2);
        check("R6 ascending second", 64'(log_vec[base+1]), 64'd6);
    endtask

    task automatic t_drop_unused();
        logic [31:0] d;
        int base;
        base = nlog;
        irq(8);
        irq(12);
        twr(1, 3, 32'd0);
        vec_used[1] = 1'b0;
        irq(1);
        cyc(2);
        check("R7 dropped requests no msg", 64'(nlog - base), 64'd0);
        prd(0, d); check("R7 dropped requests no pending", 64'(d), 64'h0);
        vec_used[1] = 1'b1;
        cyc(2);
        check("R7 no late msg", 64'(nlog - base), 64'd0);
        irq(3);
        prd(0, d); check("R7 pending before unuse", 64'(d), 64'h8);
        vec_used[3] = 1'b0;
        cyc(1);
        vec_used[3] = 1'b1;
        cyc(1);
        prd(0, d); check("R7 unuse clears pending", 64'(d), 64'h0);
    endtask

    task automatic t_backpressure();
        logic [31:0] d;
        int base;
        twr(4, 3, 32'd0);
        twr(5, 3, 32'd0);
        base = nlog;
        msg_ready = 1'b0;
        irq(5);
        irq(4);
        irq(1);
        cyc(1);
        check("R6 held valid", 64'(msg_valid), 64'd1);
        check("R6 held vector", 64'(msg_vec), 64'd5);
        check("R6 held address", msg_addr, exp_addr(5));
        prd(0, d); check("R6 busy requests pending", 64'(d), 64'h12);
        msg_ready = 1'b1;
        cyc(4);
        check("R6 drain count", 64'(nlog - base), 64'd3);
        check("R6 drain first", 64'(log_vec[base]), 64'd5);
        check("R6 drain second", 64'(log_vec[base+1]), 64'd1);
        check("R6 drain third", 64'(log_vec[base+2]), 64'd4);
        prd(0, d); check("R6 pending empty", 64'(d), 64'h0);
    endtask

    task automatic t_access_rules();
        logic [31:0] d;
        irq(0);
        pwr(0, 32'h0);
        prd(0, d); check("R9 pba write zero ignored", 64'(d), 64'h1);
        pwr(0, 32'hFFFF_FFFF);
        prd(0, d); check("R9 pba write ones ignored", 64'(d), 64'h1);
        prd(1, d); check("R8 pad dword zero", 64'(d), 64'h0);
        twr(7, 2, 32'hA1B2_C3D4);
        trd(7, 2, d); check("R10 dword readback", 64'(d), 64'hA1B2_C3D4);
        @(negedge clk);
        reg_req = 1; reg_wr = 1; reg_sel_pba = 0; reg_addr = RAW'(7 * 16 + 2 * 4 + 1); reg_wdata = 32'h0;
        @(negedge clk);
        reg_req = 0; reg_wr = 0;
        trd(7, 2, d); check("R10 misaligned write ignored", 64'(d), 64'hA1B2_C3D4);
    endtask

    task automatic t_reset_again();
        logic [31:0] d;
        @(negedge clk); rst_n = 0;
        cyc(2); rst_n = 1;
        cyc(1);
        check("R1 ctrl cleared", 64'(cfg_ctl_rdata), 64'd0);
        trd(2, 3, d); check("R1 vctrl re-masked", 64'(d), 64'd1);
        trd(2, 0, d); check("R1 table zeroed", 64'(d), 64'd0);
        prd(0, d); check("R1 pba cleared", 64'(d), 64'h0);
    endtask

    initial begin
        cyc(3);
        rst_n = 1;
        t_reset_state();
        t_program();
        t_disabled_then_enable();
        t_vector_mask();
        t_mask_all();
        t_drop_unused();
        t_backpressure();
        t_access_rules();
        t_reset_again();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule